// File: doc/BRIEF.md
# Floating-Point Add/Subtract Steering Unit

This unit sits in front of the magnitude datapath of an 80-bit extended-precision adder. Each operand arrives as a sign, a 15-bit biased exponent and a 64-bit significand carried as two 32-bit words. The operands are assumed finite and normal. An add/subtract select, a reverse flag and a 2-bit rounding-control field come with them.

From these inputs the unit works out four things:
- whether the datapath must add or subtract magnitudes;
- whether the operands must be exchanged so that the larger magnitude comes first;
- the sign of the result;
- whether the result is an exact cancellation that must be forced to zero.

The decisions are registered. They appear with a valid strobe on the cycle after an input is accepted. Alignment, the arithmetic itself and rounding belong to the downstream stages.

Top module: `fp_addsub_steer`

## Requirements
- R1: Inputs are captured on a rising clock edge with `in_valid` high. `out_valid` is high on the following cycle only, and outputs hold their last values while no new input is captured.
- R2: The reverse flag `rev` inverts both operand signs before any other decision is made.
- R3: The effective second sign is the second operand's sign, inverted when `sub_sel`=1 (subtract). When the first sign equals the effective second sign, `op_sub`=0, `swap`=0, and `result_sign` is the first operand's sign.
- R4: For subtraction, + minus − adds magnitudes with a positive result, and − minus + adds magnitudes with a negative result.
- R5: When the signs differ in effect, `op_sub`=1. The magnitudes are ordered by exponent first. If the exponents are equal, the high significand word decides. If that is also equal, the low word decides.
- R6: When `op_sub`=1 and the first magnitude is strictly larger, `swap`=0 and `result_sign` is the first operand's sign.
- R7: When `op_sub`=1 and the second magnitude is strictly larger, `swap`=1 and `result_sign` is the effective second sign. In a same-sign subtraction this is the inverted first sign.
- R8: When `op_sub`=1 and the magnitudes are exactly equal, `exact_zero`=1 and `swap`=0. `exact_zero` is 0 in every other case.
- R9: On exact cancellation, `result_sign` is 1 only when `rc`=2'b01 (round down). The other encodings are 00 nearest, 10 up and 11 toward zero, and they give sign 0.
- R10: After reset, `out_valid`, `op_sub`, `swap`, `result_sign` and `exact_zero` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand set present |
| sub_sel | input | 1 | 1 = subtract second from first, 0 = add |
| rev | input | 1 | Invert both operand signs |
| rc | input | 2 | Rounding control (00 nearest, 01 down, 10 up, 11 zero) |
| a_sign | input | 1 | First operand sign |
| a_exp | input | 15 | First operand exponent |
| a_hi | input | 32 | First operand significand high word |
| a_lo | input | 32 | First operand significand low word |
| b_sign | input | 1 | Second operand sign |
| b_exp | input | 15 | Second operand exponent |
| b_hi | input | 32 | Second operand significand high word |
| b_lo | input | 32 | Second operand significand low word |
| out_valid | output | 1 | Decision valid, one cycle after `in_valid` |
| op_sub | output | 1 | Datapath must subtract magnitudes |
| swap | output | 1 | Exchange operands so the larger comes first |
| result_sign | output | 1 | Sign of the result |
| exact_zero | output | 1 | Exact cancellation, force zero |

## Verification
The bench goes after magnitude pairs that differ only in the low word, only in the high word, or not at all. A comparator that drops a level would report equality or the wrong order there, which shows up as a wrong `swap` or a false `exact_zero`.

Exact cancellation is tried under all four rounding encodings. A wrong mode decode would give a negative zero outside round-down.

Reversed operations check that the sign inversion happens before the path choice. If it were done afterwards, + minus − would come out as a negative sum.

// File: rtl/fp_addsub_steer.sv
module fp_addsub_steer #(
  parameter int EXP_W  = 15,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              sub_sel,
  input  logic              rev,
  input  logic [1:0]        rc,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [WORD_W-1:0] a_hi,
  input  logic [WORD_W-1:0] a_lo,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [WORD_W-1:0] b_hi,
  input  logic [WORD_W-1:0] b_lo,
  output logic              out_valid,
  output logic              op_sub,
  output logic              swap,
  output logic              result_sign,
  output logic              exact_zero
);
  localparam logic [1:0] RC_DOWN = 2'b01;

  logic sa, sb_eff, diff_sign;
  logic exp_eq, hi_eq, lo_eq;
  logic a_larger, b_larger, mag_eq;
  logic n_sub, n_swap, n_sign, n_zero;

  assign sa        = a_sign ^ rev;
  assign sb_eff    = b_sign ^ rev ^ sub_sel;
  assign diff_sign = sa ^ sb_eff;

  assign exp_eq = (a_exp == b_exp);
  assign hi_eq  = (a_hi == b_hi);
  assign lo_eq  = (a_lo == b_lo);

  assign a_larger = (a_exp > b_exp) ||
                    (exp_eq && (a_hi > b_hi)) ||
                    (exp_eq && hi_eq && (a_lo > b_lo));
  assign b_larger = (a_exp < b_exp) ||
                    (exp_eq && (a_hi < b_hi)) ||
                    (exp_eq && hi_eq && (a_lo < b_lo));
  assign mag_eq   = exp_eq && hi_eq && lo_eq;

  always_comb begin
    n_sub  = diff_sign;
    n_swap = 1'b0;
    n_zero = 1'b0;
    n_sign = sa;
    if (diff_sign) begin
      if (b_larger) begin
        n_swap = 1'b1;
        n_sign = sb_eff;
      end else if (mag_eq && !a_larger) begin
        n_zero = 1'b1;
        n_sign = (rc == RC_DOWN);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      op_sub      <= 1'b0;
      swap        <= 1'b0;
      result_sign <= 1'b0;
      exact_zero  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        op_sub      <= n_sub;
        swap        <= n_swap;
        result_sign <= n_sign;
        exact_zero  <= n_zero;
      end
    end
  end
endmodule

// File: rtl/fp_addsub_steer_chk.sv
module fp_addsub_steer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       rev,
  input logic [1:0] rc,
  input logic       a_sign,
  input logic       out_valid,
  input logic       op_sub,
  input logic       swap,
  input logic       result_sign,
  input logic       exact_zero
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(op_sub) && $stable(swap) && $stable(result_sign) && $stable(exact_zero)));

  p_add_keeps_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!op_sub -> (!swap && result_sign == ($past(a_sign) ^ $past(rev)))));

  p_zero_needs_sub_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exact_zero |-> (op_sub && !swap));

  p_zero_sign_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (exact_zero -> (result_sign == ($past(rc) == 2'b01))));
endmodule

bind fp_addsub_steer fp_addsub_steer_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .rev(rev), .rc(rc),
  .a_sign(a_sign), .out_valid(out_valid), .op_sub(op_sub), .swap(swap),
  .result_sign(result_sign), .exact_zero(exact_zero)
);

// File: tb/fp_addsub_steer_tb_top.sv
module fp_addsub_steer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, sub_sel = 1'b0, rev = 1'b0;
  logic [1:0] rc = 2'b00;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [14:0] a_exp = '0, b_exp = '0;
  logic [31:0] a_hi = '0, a_lo = '0, b_hi = '0, b_lo = '0;
  logic out_valid, op_sub, swap, result_sign, exact_zero;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fp_addsub_steer dut_i (.*);

  // vector: sub rev rc | as aexp ahi alo | bs bexp bhi blo | {op_sub swap sign zero}
  localparam int NV = 16;
  localparam logic [167:0] VEC [NV] = '{
    {1'b0,1'b0,2'b00, 1'b0,15'h3fff,32'h80000000,32'h0, 1'b0,15'h4000,32'h80000000,32'h0, 4'b0000},
    {1'b0,1'b0,2'b00, 1'b1,15'h4000,32'h80000000,32'h0, 1'b0,15'h3fff,32'h80000000,32'h0, 4'b1010},
    {1'b0,1'b0,2'b00, 1'b0,15'h3fff,32'h80000000,32'h0, 1'b1,15'h4000,32'h80000000,32'h0, 4'b1110},
    {1'b1,1'b0,2'b00, 1'b0,15'h4000,32'h90000000,32'h0, 1'b0,15'h4000,32'h80000001,32'h0, 4'b1000},
    {1'b1,1'b0,2'b00, 1'b0,15'h4000,32'h80000000,32'h5, 1'b0,15'h4000,32'h80000000,32'h6, 4'b1110},
    {1'b1,1'b0,2'b00, 1'b1,15'h4000,32'h80000000,32'h7, 1'b1,15'h4000,32'h80000000,32'h6, 4'b1010},
    {1'b1,1'b0,2'b00, 1'b0,15'h1234,32'h80000000,32'h0, 1'b1,15'h4321,32'h80000000,32'h0, 4'b0000},
    {1'b1,1'b0,2'b00, 1'b1,15'h1234,32'h80000000,32'h0, 1'b0,15'h4321,32'h80000000,32'h0, 4'b0010},
    {1'b1,1'b0,2'b00, 1'b0,15'h4000,32'hc0000000,32'h9, 1'b0,15'h4000,32'hc0000000,32'h9, 4'b1001},
    {1'b1,1'b0,2'b01, 1'b0,15'h4000,32'hc0000000,32'h9, 1'b0,15'h4000,32'hc0000000,32'h9, 4'b1011},
    {1'b1,1'b0,2'b10, 1'b1,15'h4000,32'hc0000000,32'h9, 1'b1,15'h4000,32'hc0000000,32'h9, 4'b1001},
    {1'b1,1'b0,2'b11, 1'b1,15'h4000,32'hc0000000,32'h9, 1'b1,15'h4000,32'hc0000000,32'h9, 4'b1001},
    {1'b0,1'b0,2'b01, 1'b0,15'h2222,32'hffffffff,32'h1, 1'b1,15'h2222,32'hffffffff,32'h1, 4'b1011},
    {1'b1,1'b1,2'b00, 1'b0,15'h4001,32'h80000000,32'h0, 1'b0,15'h4000,32'h80000000,32'h0, 4'b1010},
    {1'b0,1'b1,2'b00, 1'b0,15'h3000,32'h80000000,32'h0, 1'b1,15'h4000,32'h80000000,32'h0, 4'b1100},
    {1'b1,1'b1,2'b00, 1'b0,15'h3000,32'h80000000,32'h0, 1'b1,15'h4000,32'h80000000,32'h0, 4'b0010}
  };

  function automatic logic [3:0] ref_model(input logic s, input logic r, input logic [1:0] m,
      input logic as, input logic [14:0] ae, input logic [63:0] am,
      input logic bs, input logic [14:0] be, input logic [63:0] bm);
    logic x, y;
    logic [78:0] ma, mb;
    x  = as ^ r;
    y  = bs ^ r ^ s;
    ma = {ae, am};
    mb = {be, bm};
    if (x == y) return {1'b0, 1'b0, x, 1'b0};
    if (ma > mb) return {1'b1, 1'b0, x, 1'b0};
    if (ma < mb) return {1'b1, 1'b1, y, 1'b0};
    return {1'b1, 1'b0, (m == 2'b01), 1'b1};
  endfunction

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got {v,sub,swap,sign,zero}=%b expected %b", req, got, exp);
    end
  endtask

  task automatic apply(input logic [167:0] v, input string req);
    @(negedge clk);
    {sub_sel, rev, rc, a_sign, a_exp, a_hi, a_lo, b_sign, b_exp, b_hi, b_lo} = v[167:4];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, op_sub, swap, result_sign, exact_zero}, {1'b1, v[3:0]});
  endtask

  function automatic logic [167:0] build(input logic s, input logic r, input logic [1:0] m,
      input logic as, input logic [14:0] ae, input logic [63:0] am,
      input logic bs, input logic [14:0] be, input logic [63:0] bm);
    return {s, r, m, as, ae, am, bs, be, bm,
            ref_model(s, r, m, as, ae, am, bs, be, bm)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {out_valid, op_sub, swap, result_sign, exact_zero}, 5'b00000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {out_valid, op_sub, swap, result_sign, exact_zero}, 5'b00000);

    // R2 R3 R4 R5 R6 R7 R8 R9: table of directed vectors
    for (int i = 0; i < NV; i++) apply(VEC[i], "R2-table R3 R4 R5 R6 R7 R8 R9");

    // R1: outputs hold and strobe drops while in_valid is low
    apply(VEC[9], "R9");
    @(negedge clk);
    {sub_sel, a_sign, b_sign, rc} = {1'b0, 1'b0, 1'b0, 2'b00};
    a_exp = 15'h10; b_exp = 15'h20;
    @(negedge clk);
    check("R1", {out_valid, op_sub, swap, result_sign, exact_zero}, 5'b01011);

    // R5: one low bit differs, both orders
    apply(build(1'b1, 1'b0, 2'b00, 1'b0, 15'h5, 64'h8000000000000001,
                1'b0, 15'h5, 64'h8000000000000000), "R5");
    apply(build(1'b1, 1'b0, 2'b00, 1'b0, 15'h5, 64'h8000000000000000,
                1'b0, 15'h5, 64'h8000000000000001), "R5");

    // R6 R7: random operands with close magnitudes
    for (int i = 0; i < 300; i++) begin
      logic [14:0] e1, e2;
      logic [63:0] m1, m2;
      e1 = 15'($urandom_range(0, 3)) + 15'h3ffe;
      e2 = 15'($urandom_range(0, 3)) + 15'h3ffe;
      m1 = {1'b1, 31'($urandom_range(0, 2)), 32'($urandom_range(0, 3))};
      m2 = {1'b1, 31'($urandom_range(0, 2)), 32'($urandom_range(0, 3))};
      apply(build(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), e1, m1,
                  1'($urandom), e2, m2), "R6 R7 random");
    end

    // R8 R9: equal magnitudes, all modes
    for (int i = 0; i < 100; i++) begin
      logic [14:0] e1;
      logic [63:0] m1;
      e1 = 15'($urandom);
      m1 = {1'b1, 31'($urandom), 32'($urandom)};
      apply(build(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), e1, m1,
                  1'($urandom), e1, m1), "R8 R9 equal");
    end

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule